// File: doc/BRIEF.md
# Symbol-Spaced Adaptive QAM Equalizer with Tap-Derived Timing Error

This block is a complex, one-sample-per-symbol adaptive FIR equalizer for square QAM. Each strobe brings in one I/Q sample. The block filters the sample with its complex taps and slices the result to the nearest constellation point. It then adapts every tap by LMS on the decision error. It returns the equalized sample and the decided symbol code.

The taps also drive a timing-error word for an external timing loop. This word is the difference between the taps just after and just before the centre tap. No separate timing detector is needed.

The LMS step is a power-of-two right shift. It starts coarse and gets one shift finer when the symbol count passes one third of the programmed burst length, and again at two thirds. The count wraps at the end of each burst, so every burst starts again from the coarse step.

Top module: `sym_eq_top`

## Requirements
- R1: After reset, the centre tap (index NTAP/2) is 1.0 (2^TFRAC on the real part) and every other tap is zero. The timing error is zero, valid_o is low, y and sym outputs are zero, and the step shift is 3.
- R2: On a strobe, y = saturate_DW((sum over k of w[k]*x[n-k]) >>> TFRAC), with complex products and floor shifting. Here x[n-k] is the sample from k strobes earlier, taken as zero before reset. y and sym are registered, and valid_o goes high in the cycle after valid_i.
- R3: Without a strobe, the taps, the timing error, y_re_o, y_im_o, sym_o and the step shift stay unchanged.
- R4: In 16-QAM mode (qam16_i=1), each axis decides among levels -384, -128, 128, 384 with codes 0, 1, 2, 3. The boundaries are -256, 0 and 256, and a value on a boundary takes the higher level. sym_o = {imag code, real code}.
- R5: In 4-QAM mode, each axis decides +256 (code 1) when the value is >= 0 and -256 (code 0) otherwise. sym_o = {2'b00, imag code, real code}.
- R6: On each strobe every tap updates as w[k] += (e*conj(x[n-k])) >>> (2*DFRAC-TFRAC+shift), with e = decision - y. Each component saturates to TW bits.
- R7: terr_re_o/terr_im_o = w[NTAP/2+1] - w[NTAP/2-1], taken from the current taps.
- R8: With L = burst_len_i and count c of strobes already taken in the burst, the shift is 3 for c < L/3, 4 for c < 2L/3, and 5 otherwise (integer division). mu_shift_o shows the shift that the next strobe will use.
- R9: The burst count returns to zero after L strobes, so the shift goes back to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe, one per symbol |
| x_re_i | input | DW | Input sample, real part, signed, DFRAC fraction bits |
| x_im_i | input | DW | Input sample, imaginary part |
| qam16_i | input | 1 | 1: 16-QAM slicing, 0: 4-QAM |
| burst_len_i | input | BLW | Burst length in symbols |
| valid_o | output | 1 | Output strobe |
| y_re_o | output | DW | Equalized sample, real part |
| y_im_o | output | DW | Equalized sample, imaginary part |
| sym_o | output | 4 | Decided symbol code |
| terr_re_o | output | TW+1 | Timing error, real part |
| terr_im_o | output | TW+1 | Timing error, imaginary part |
| mu_shift_o | output | MUW | Step-size shift for the next strobe |

## Verification
The bench builds the block at its defaults: seven taps, 12-bit samples with 8 fraction bits, and 16-bit taps with 12 fraction bits. With these widths every slicer level, error and tap increment is a whole number, so the first few strobes after reset can be worked out by hand. That hand-worked set includes the timing error swinging to -256 and back to zero as one pulse moves past the centre tap.

A burst length of 9 places both step-halving points and the burst wrap within ten strobes. A mixed vector walk, checked against an integer model, drives the outputs and taps into saturation in both slicer modes.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    PH_COARSE = 2'd0,
    PH_MID    = 2'd1,
    PH_FINE   = 2'd2
  } mu_phase_e;

  localparam int unsigned MU_BASE = 3;
endpackage

// File: rtl/seq_mu_sched.sv
module seq_mu_sched #(
  parameter int BLW = 16,
  parameter int MUW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           adv_i,
  input  logic [BLW-1:0] len_i,
  output logic [MUW-1:0] mu_o
);
  import seq_pkg::*;

  localparam int XW = BLW + 2;

  logic [BLW-1:0] cnt_q;
  logic [XW-1:0]  len_x, cnt_x, t1, t2, nxt;
  mu_phase_e      ph;

  always_comb begin
    len_x = XW'(len_i);
    cnt_x = XW'(cnt_q);
    t1    = len_x / XW'(3);
    t2    = (len_x << 1) / XW'(3);
    nxt   = cnt_x + XW'(1);
    if (cnt_x < t1)      ph = PH_COARSE;
    else if (cnt_x < t2) ph = PH_MID;
    else                 ph = PH_FINE;
    mu_o = MUW'(MU_BASE) + MUW'(ph);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (adv_i) cnt_q <= (nxt >= len_x) ? '0 : nxt[BLW-1:0];
  end
endmodule

// File: rtl/seq_axis_slice.sv
module seq_axis_slice #(
  parameter int DW    = 12,
  parameter int DFRAC = 8
) (
  input  logic signed [DW-1:0] y_i,
  input  logic                 qam16_i,
  output logic signed [DW-1:0] lvl_o,
  output logic [1:0]           code_o
);
  localparam logic signed [DW-1:0] H1 = DW'(1 << (DFRAC - 1));
  localparam logic signed [DW-1:0] H2 = DW'(2 << (DFRAC - 1));
  localparam logic signed [DW-1:0] H3 = DW'(3 << (DFRAC - 1));
  localparam logic signed [DW-1:0] ZR = '0;

  always_comb begin
    if (qam16_i) begin
      if (y_i >= H2)       begin lvl_o = H3;  code_o = 2'd3; end
      else if (y_i >= ZR)  begin lvl_o = H1;  code_o = 2'd2; end
      else if (y_i >= -H2) begin lvl_o = -H1; code_o = 2'd1; end
      else                 begin lvl_o = -H3; code_o = 2'd0; end
    end else begin
      if (y_i >= ZR) begin lvl_o = H2;  code_o = 2'd1; end
      else           begin lvl_o = -H2; code_o = 2'd0; end
    end
  end
endmodule

// File: rtl/seq_tap_cell.sv
module seq_tap_cell #(
  parameter int DW      = 12,
  parameter int TW      = 16,
  parameter int MUW     = 3,
  parameter int SHB     = 4,
  parameter int INIT_RE = 0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [MUW-1:0]       mu_i,
  input  logic signed [DW:0]   e_re_i,
  input  logic signed [DW:0]   e_im_i,
  input  logic signed [DW-1:0] x_re_i,
  input  logic signed [DW-1:0] x_im_i,
  output logic signed [TW-1:0] w_re_o,
  output logic signed [TW-1:0] w_im_o
);
  localparam int PW = 2 * DW + 2;
  localparam logic signed [PW:0] SMAX = (PW+1)'((2 ** (TW - 1)) - 1);
  localparam logic signed [PW:0] SMIN = -SMAX - (PW+1)'(1);

  logic signed [PW-1:0] g_re, g_im, st_re, st_im;
  logic signed [PW:0]   s_re, s_im;
  logic signed [TW-1:0] n_re, n_im;

  always_comb begin
    // e * conj(x)
    g_re  = PW'(e_re_i) * PW'(x_re_i) + PW'(e_im_i) * PW'(x_im_i);
    g_im  = PW'(e_im_i) * PW'(x_re_i) - PW'(e_re_i) * PW'(x_im_i);
    st_re = g_re >>> (SHB + int'(mu_i));
    st_im = g_im >>> (SHB + int'(mu_i));
    s_re  = (PW+1)'(w_re_o) + (PW+1)'(st_re);
    s_im  = (PW+1)'(w_im_o) + (PW+1)'(st_im);
    n_re  = (s_re > SMAX) ? SMAX[TW-1:0] : (s_re < SMIN) ? SMIN[TW-1:0] : s_re[TW-1:0];
    n_im  = (s_im > SMAX) ? SMAX[TW-1:0] : (s_im < SMIN) ? SMIN[TW-1:0] : s_im[TW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_re_o <= TW'(INIT_RE);
      w_im_o <= '0;
    end else if (en_i) begin
      w_re_o <= n_re;
      w_im_o <= n_im;
    end
  end
endmodule

// File: rtl/sym_eq_top.sv
module sym_eq_top #(
  parameter int DW    = 12,
  parameter int DFRAC = 8,
  parameter int TW    = 16,
  parameter int TFRAC = 12,
  parameter int NTAP  = 7,
  parameter int BLW   = 16,
  parameter int MUW   = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [DW-1:0] x_re_i,
  input  logic signed [DW-1:0] x_im_i,
  input  logic                 qam16_i,
  input  logic [BLW-1:0]       burst_len_i,
  output logic                 valid_o,
  output logic signed [DW-1:0] y_re_o,
  output logic signed [DW-1:0] y_im_o,
  output logic [3:0]           sym_o,
  output logic signed [TW:0]   terr_re_o,
  output logic signed [TW:0]   terr_im_o,
  output logic [MUW-1:0]       mu_shift_o
);
  localparam int CTR = NTAP / 2;
  localparam int EW  = DW + 1;
  localparam int ACW = TW + DW + 2 + $clog2(NTAP);
  localparam int SHB = 2 * DFRAC - TFRAC;
  localparam logic signed [ACW-1:0] YMAX = ACW'((2 ** (DW - 1)) - 1);
  localparam logic signed [ACW-1:0] YMIN = -YMAX - ACW'(1);

  logic signed [DW-1:0]  hre_q [NTAP-1];
  logic signed [DW-1:0]  him_q [NTAP-1];
  logic signed [DW-1:0]  win_re [NTAP];
  logic signed [DW-1:0]  win_im [NTAP];
  logic signed [TW-1:0]  w_re [NTAP];
  logic signed [TW-1:0]  w_im [NTAP];
  logic signed [ACW-1:0] acc_re, acc_im, ys_re, ys_im;
  logic signed [DW-1:0]  y_re, y_im, d_re, d_im;
  logic signed [EW-1:0]  e_re, e_im;
  logic [1:0]            c_re, c_im;
  logic [MUW-1:0]        mu;

  always_comb begin
    win_re[0] = x_re_i;
    win_im[0] = x_im_i;
    for (int k = 1; k < NTAP; k++) begin
      win_re[k] = hre_q[k-1];
      win_im[k] = him_q[k-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NTAP - 1; k++) begin
        hre_q[k] <= '0;
        him_q[k] <= '0;
      end
    end else if (valid_i) begin
      for (int k = 0; k < NTAP - 1; k++) begin
        hre_q[k] <= win_re[k];
        him_q[k] <= win_im[k];
      end
    end
  end

  always_comb begin
    acc_re = '0;
    acc_im = '0;
    for (int k = 0; k < NTAP; k++) begin
      acc_re = acc_re + ACW'(w_re[k]) * ACW'(win_re[k]) - ACW'(w_im[k]) * ACW'(win_im[k]);
      acc_im = acc_im + ACW'(w_re[k]) * ACW'(win_im[k]) + ACW'(w_im[k]) * ACW'(win_re[k]);
    end
    ys_re = acc_re >>> TFRAC;
    ys_im = acc_im >>> TFRAC;
    y_re  = (ys_re > YMAX) ? YMAX[DW-1:0] : (ys_re < YMIN) ? YMIN[DW-1:0] : ys_re[DW-1:0];
    y_im  = (ys_im > YMAX) ? YMAX[DW-1:0] : (ys_im < YMIN) ? YMIN[DW-1:0] : ys_im[DW-1:0];
  end

  seq_axis_slice #(.DW(DW), .DFRAC(DFRAC)) u_sl_re (
    .y_i(y_re), .qam16_i(qam16_i), .lvl_o(d_re), .code_o(c_re)
  );
  seq_axis_slice #(.DW(DW), .DFRAC(DFRAC)) u_sl_im (
    .y_i(y_im), .qam16_i(qam16_i), .lvl_o(d_im), .code_o(c_im)
  );

  assign e_re = EW'(d_re) - EW'(y_re);
  assign e_im = EW'(d_im) - EW'(y_im);

  seq_mu_sched #(.BLW(BLW), .MUW(MUW)) u_mu (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(valid_i), .len_i(burst_len_i), .mu_o(mu)
  );

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    seq_tap_cell #(
      .DW(DW), .TW(TW), .MUW(MUW), .SHB(SHB),
      .INIT_RE((k == CTR) ? (1 << TFRAC) : 0)
    ) u_tap (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(valid_i), .mu_i(mu),
      .e_re_i(e_re), .e_im_i(e_im), .x_re_i(win_re[k]), .x_im_i(win_im[k]),
      .w_re_o(w_re[k]), .w_im_o(w_im[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      y_re_o  <= '0;
      y_im_o  <= '0;
      sym_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        y_re_o <= y_re;
        y_im_o <= y_im;
        sym_o  <= qam16_i ? {c_im, c_re} : {2'b00, c_im[0], c_re[0]};
      end
    end
  end

  assign terr_re_o  = (TW+1)'(w_re[CTR+1]) - (TW+1)'(w_re[CTR-1]);
  assign terr_im_o  = (TW+1)'(w_im[CTR+1]) - (TW+1)'(w_im[CTR-1]);
  assign mu_shift_o = mu;
endmodule

// File: rtl/seq_eq_chk.sv
module seq_eq_chk #(
  parameter int DW  = 12,
  parameter int TW  = 16,
  parameter int BLW = 16,
  parameter int MUW = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic                 qam16_i,
  input logic [BLW-1:0]       burst_len_i,
  input logic                 valid_o,
  input logic signed [DW-1:0] y_re_o,
  input logic signed [DW-1:0] y_im_o,
  input logic [3:0]           sym_o,
  input logic signed [TW:0]   terr_re_o,
  input logic signed [TW:0]   terr_im_o,
  input logic [MUW-1:0]       mu_shift_o
);
  // R2
  vld_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R2
  vld_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R3
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(y_re_o) && $stable(y_im_o) && $stable(sym_o)));
  // R3
  terr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(terr_re_o) && $stable(terr_im_o)));
  // R8
  mu_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && $stable(burst_len_i)) |=> $stable(mu_shift_o));
  // R8
  mu_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mu_shift_o >= MUW'(3)) && (mu_shift_o <= MUW'(5)));
  // R5
  qpsk_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !qam16_i) |=> (sym_o[3:2] == 2'b00));
endmodule

bind sym_eq_top seq_eq_chk #(.DW(DW), .TW(TW), .BLW(BLW), .MUW(MUW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .qam16_i(qam16_i),
  .burst_len_i(burst_len_i), .valid_o(valid_o), .y_re_o(y_re_o), .y_im_o(y_im_o),
  .sym_o(sym_o), .terr_re_o(terr_re_o), .terr_im_o(terr_im_o), .mu_shift_o(mu_shift_o)
);

// File: tb/sym_eq_top_tb_top.sv
module sym_eq_top_tb_top;
  localparam int DW = 12, DFRAC = 8, TW = 16, TFRAC = 12, NTAP = 7, BLW = 16, MUW = 3;
  localparam int CTR = NTAP / 2;
  localparam int NV  = 16;

  typedef struct packed {
    logic signed [DW-1:0] re;
    logic signed [DW-1:0] im;
    logic                 q16;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{12'sd384, -12'sd128, 1'b1}, '{-12'sd128, 12'sd128, 1'b1},
    '{12'sd130, -12'sd390, 1'b1}, '{-12'sd400, 12'sd260, 1'b1},
    '{12'sd0, 12'sd0, 1'b1},      '{12'sd250, -12'sd250, 1'b0},
    '{-12'sd260, 12'sd10, 1'b0},  '{12'sd384, 12'sd384, 1'b1},
    '{-12'sd384, -12'sd384, 1'b1}, '{12'sd127, -12'sd129, 1'b1},
    '{12'sd256, -12'sd256, 1'b1}, '{-12'sd256, 12'sd255, 1'b1},
    '{12'sd1000, -12'sd1000, 1'b1}, '{-12'sd2048, 12'sd2047, 1'b0},
    '{12'sd60, -12'sd70, 1'b0},   '{12'sd300, 12'sd300, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic signed [DW-1:0] x_re_i = '0, x_im_i = '0;
  logic qam16_i = 1'b1;
  logic [BLW-1:0] burst_len_i = 16'd300;
  logic valid_o;
  logic signed [DW-1:0] y_re_o, y_im_o;
  logic [3:0] sym_o;
  logic signed [TW:0] terr_re_o, terr_im_o;
  logic [MUW-1:0] mu_shift_o;

  always #2 clk = ~clk;

  sym_eq_top #(.DW(DW), .DFRAC(DFRAC), .TW(TW), .TFRAC(TFRAC), .NTAP(NTAP),
               .BLW(BLW), .MUW(MUW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .x_re_i(x_re_i), .x_im_i(x_im_i),
    .qam16_i(qam16_i), .burst_len_i(burst_len_i), .valid_o(valid_o), .y_re_o(y_re_o),
    .y_im_o(y_im_o), .sym_o(sym_o), .terr_re_o(terr_re_o), .terr_im_o(terr_im_o),
    .mu_shift_o(mu_shift_o)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  longint mw_re [NTAP], mw_im [NTAP], mh_re [NTAP], mh_im [NTAP];
  longint mcnt, mlen;
  longint ey_re, ey_im, et_re, et_im, emu;
  longint esym;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint msat(input longint v, input int b);
    longint mx = (longint'(1) <<< (b - 1)) - 1;
    if (v > mx) return mx;
    if (v < -mx - 1) return -mx - 1;
    return v;
  endfunction

  function automatic longint mshift(input longint c, input longint l);
    if (c < l / 3) return 3;
    if (c < (2 * l) / 3) return 4;
    return 5;
  endfunction

  task automatic decide(input longint y, input bit q16, output longint lvl, output longint code);
    if (q16) begin
      if (y >= 256)       begin lvl = 384;  code = 3; end
      else if (y >= 0)    begin lvl = 128;  code = 2; end
      else if (y >= -256) begin lvl = -128; code = 1; end
      else                begin lvl = -384; code = 0; end
    end else begin
      if (y >= 0) begin lvl = 256; code = 1; end
      else        begin lvl = -256; code = 0; end
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < NTAP; k++) begin
      mw_re[k] = (k == CTR) ? (longint'(1) <<< TFRAC) : 0;
      mw_im[k] = 0;
      mh_re[k] = 0;
      mh_im[k] = 0;
    end
    mcnt = 0;
  endtask

  task automatic model_step(input longint xr, input longint xi, input bit q16);
    longint wr [NTAP];
    longint wi [NTAP];
    longint ar, ai, dr, di, cr, ci, er, ei, gr, gi, mu;
    wr[0] = xr; wi[0] = xi;
    for (int k = 1; k < NTAP; k++) begin wr[k] = mh_re[k-1]; wi[k] = mh_im[k-1]; end
    ar = 0; ai = 0;
    for (int k = 0; k < NTAP; k++) begin
      ar += mw_re[k] * wr[k] - mw_im[k] * wi[k];
      ai += mw_re[k] * wi[k] + mw_im[k] * wr[k];
    end
    ey_re = msat(ar >>> TFRAC, DW);
    ey_im = msat(ai >>> TFRAC, DW);
    decide(ey_re, q16, dr, cr);
    decide(ey_im, q16, di, ci);
    esym = q16 ? (ci * 4 + cr) : (ci * 2 + cr);
    er = dr - ey_re;
    ei = di - ey_im;
    mu = mshift(mcnt, mlen);
    for (int k = 0; k < NTAP; k++) begin
      gr = er * wr[k] + ei * wi[k];
      gi = ei * wr[k] - er * wi[k];
      mw_re[k] = msat(mw_re[k] + (gr >>> (2 * DFRAC - TFRAC + mu)), TW);
      mw_im[k] = msat(mw_im[k] + (gi >>> (2 * DFRAC - TFRAC + mu)), TW);
    end
    for (int k = NTAP - 2; k >= 1; k--) begin mh_re[k] = mh_re[k-1]; mh_im[k] = mh_im[k-1]; end
    mh_re[0] = xr; mh_im[0] = xi;
    mcnt = (mcnt + 1 >= mlen) ? 0 : mcnt + 1;
    et_re = mw_re[CTR+1] - mw_re[CTR-1];
    et_im = mw_im[CTR+1] - mw_im[CTR-1];
    emu = mshift(mcnt, mlen);
  endtask

  task automatic do_reset(input int len);
    @(negedge clk);
    rst_ni = 1'b0;
    valid_i = 1'b0;
    burst_len_i = BLW'(len);
    mlen = len;
    repeat (3) @(negedge clk);
    model_reset();
    rst_ni = 1'b1;
  endtask

  task automatic strobe(input longint xr, input longint xi, input bit q16, input bit cmp);
    @(negedge clk);
    x_re_i = DW'(xr);
    x_im_i = DW'(xi);
    qam16_i = q16;
    valid_i = 1'b1;
    model_step(xr, xi, q16);
    @(negedge clk);
    valid_i = 1'b0;
    if (cmp) begin
      chk("R2", "valid_o", longint'(valid_o), 1);
      chk("R2", "y_re", longint'(y_re_o), ey_re);
      chk("R2", "y_im", longint'(y_im_o), ey_im);
      chk(q16 ? "R4" : "R5", "sym", longint'(sym_o), esym);
      chk("R6", "terr_re", longint'(terr_re_o), et_re);
      chk("R6", "terr_im", longint'(terr_im_o), et_im);
      chk("R8", "mu_shift", longint'(mu_shift_o), emu);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    longint hy_re, hy_im, hs, ht_re, ht_im;
    // R1 reset state
    do_reset(300);
    @(negedge clk);
    chk("R1", "valid_o", longint'(valid_o), 0);
    chk("R1", "y_re", longint'(y_re_o), 0);
    chk("R1", "y_im", longint'(y_im_o), 0);
    chk("R1", "sym", longint'(sym_o), 0);
    chk("R1", "terr_re", longint'(terr_re_o), 0);
    chk("R1", "terr_im", longint'(terr_im_o), 0);
    chk("R1", "mu_shift", longint'(mu_shift_o), 3);

    // hand-worked pulse past the centre tap, 16-QAM
    strobe(256, 0, 1'b1, 1'b0);
    chk("R4", "sym y=0", longint'(sym_o), 4'b1010);
    chk("R2", "y_re first", longint'(y_re_o), 0);
    strobe(0, 0, 1'b1, 1'b0);
    strobe(0, 0, 1'b1, 1'b0);
    chk("R7", "terr_re after 3", longint'(terr_re_o), -256);
    chk("R6", "terr_im after 3", longint'(terr_im_o), -256);
    strobe(0, 0, 1'b1, 1'b0);
    chk("R2", "y_re delayed", longint'(y_re_o), 256);
    chk("R2", "y_im delayed", longint'(y_im_o), 0);
    chk("R4", "sym boundary 256", longint'(sym_o), 4'b1011);
    strobe(0, 0, 1'b1, 1'b0);
    chk("R7", "terr_re after 5", longint'(terr_re_o), 0);
    chk("R7", "terr_im after 5", longint'(terr_im_o), 0);

    // R3 no strobe: outputs and timing error hold while inputs move
    hy_re = y_re_o; hy_im = y_im_o; hs = sym_o; ht_re = terr_re_o; ht_im = terr_im_o;
    x_re_i = 12'sd900; x_im_i = -12'sd900; qam16_i = 1'b0;
    repeat (5) @(negedge clk);
    chk("R3", "y_re hold", longint'(y_re_o), hy_re);
    chk("R3", "y_im hold", longint'(y_im_o), hy_im);
    chk("R3", "sym hold", longint'(sym_o), hs);
    chk("R3", "terr hold", longint'(terr_re_o) + longint'(terr_im_o), ht_re + ht_im);
    chk("R3", "valid_o low", longint'(valid_o), 0);
    chk("R3", "mu hold", longint'(mu_shift_o), 3);

    // R5 4-QAM hand cases
    do_reset(300);
    strobe(-5, 7, 1'b0, 1'b0);
    chk("R5", "sym y=0", longint'(sym_o), 4'b0011);
    strobe(-300, -300, 1'b0, 1'b0);
    chk("R5", "y_re", longint'(y_re_o), -3);
    chk("R5", "y_im", longint'(y_im_o), 1);
    chk("R5", "sym mixed", longint'(sym_o), 4'b0010);

    // R8 R9 step schedule with burst of 9
    do_reset(9);
    for (int i = 1; i <= 10; i++) begin
      strobe(0, 0, 1'b1, 1'b0);
      chk((i % 9 == 0) ? "R9" : "R8", $sformatf("mu after %0d", i), longint'(mu_shift_o),
          ((i % 9) < 3) ? 3 : ((i % 9) < 6) ? 4 : 5);
    end
    chk("R3", "terr zero input", longint'(terr_re_o), 0);

    // vector walk against the integer model (R2 R4 R5 R6 R7 R8)
    do_reset(12);
    for (int pass = 0; pass < 3; pass++) begin
      for (int i = 0; i < NV; i++) begin
        strobe(longint'(VEC[i].re), longint'(VEC[i].im), VEC[i].q16, 1'b1);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule